// File: doc/BRIEF.md
# Two-Die Roll Generator

This block turns the length of a button press into the outcome of a throw of two dice. Two face counters run at the system clock. They step only while the roll enable input is high, so the number of clock cycles the player holds the button selects the result. The first die steps on every enabled clock. The second die steps only on the enabled clock where the first die wraps from its highest face back to one. Between them the two counters walk through every pair of faces, and each pair is held for the same number of cycles.

When the enable drops, both dice freeze and keep their values for display until the next press. From the registered dice the block forms a registered total and three registered flags on that total. A game controller uses the flags to settle the first throw: one flag for seven, one for seven or eleven, and one for two, three or twelve. All of these outputs lag the dice by one clock. Once the enable has been low for a cycle they are stable and agree with the dice shown.

Top module: `dice_roller`

## Requirements
- R1: Each die output (`die_a`, `die_b`) always lies in the range 1 to FACES inclusive (1 to 6 by default).
- R2: On every rising clock edge with `roll_en` high and `rst` low, `die_a` advances by one, and it wraps from FACES to 1.
- R3: `die_b` changes only on an enabled edge where `die_a` was FACES. It then advances by one and wraps from FACES to 1. After n enabled edges from reset, `die_a` = (n mod FACES)+1 and `die_b` = ((n div FACES) mod FACES)+1.
- R4: While `roll_en` is low, both die outputs hold their values.
- R5: Reset is synchronous and active high, and it takes priority over `roll_en`. After a reset edge both dice are 1, `sum` is 2, `sum_is_7` and `sum_7_or_11` are 0, and `sum_2_3_12` is 1.
- R6: `sum` equals `die_a + die_b` as they were before the previous rising edge, so it has a latency of one clock. Its range is 2 to 2*FACES.
- R7: `sum_is_7` is 1 exactly when `sum` is FACES+1 (7 by default).
- R8: `sum_7_or_11` is 1 exactly when `sum` is FACES+1 or 2*FACES-1 (7 or 11 by default).
- R9: `sum_2_3_12` is 1 exactly when `sum` is 2, 3 or 2*FACES (2, 3 or 12 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| roll_en | input | 1 | Roll enable; the counters step while high |
| die_a | output | FACE_W (3) | First die face, 1..FACES |
| die_b | output | FACE_W (3) | Second die face, 1..FACES |
| sum | output | SUM_W (4) | Registered total of both dice |
| sum_is_7 | output | 1 | Registered flag: total is seven |
| sum_7_or_11 | output | 1 | Registered flag: total is seven or eleven |
| sum_2_3_12 | output | 1 | Registered flag: total is two, three or twelve |

## Verification
The bench builds the block with its default of six faces. At that size all 36 face pairs, and each wrap of both dice, are reached within a few dozen enabled cycles. Press lengths from 0 to 71 cycles are swept after a fresh reset, which covers every total and every flag pattern twice, including the double wrap back to (1,1). A continuous-enable run checks the dice on every cycle and the one-cycle lag of the total. A separate case checks that reset wins over an active enable.

// File: rtl/dice_pkg.sv
package dice_pkg;

  typedef struct packed {
    logic seven;
    logic seven_or_eleven;
    logic two_three_twelve;
  } roll_flags_t;

  function automatic roll_flags_t classify_total(input int total, input int faces);
    roll_flags_t f;
    f.seven            = (total == faces + 1);
    f.seven_or_eleven  = (total == faces + 1) || (total == 2 * faces - 1);
    f.two_three_twelve = (total == 2) || (total == 3) || (total == 2 * faces);
    return f;
  endfunction

endpackage

// File: rtl/dice_face_counter.sv
module dice_face_counter #(
  parameter int FACES  = 6,
  parameter int FACE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [FACE_W-1:0] face
);

  localparam logic [FACE_W-1:0] TOP = FACE_W'(FACES);
  localparam logic [FACE_W-1:0] ONE = FACE_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      face <= ONE;
    end else if (step) begin
      if (face == TOP) face <= ONE;
      else             face <= face + ONE;
    end
  end

endmodule

// File: rtl/dice_sum_decode.sv
module dice_sum_decode #(
  parameter int FACES  = 6,
  parameter int FACE_W = 3,
  parameter int SUM_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FACE_W-1:0] face_a,
  input  logic [FACE_W-1:0] face_b,
  output logic [SUM_W-1:0]  total,
  output dice_pkg::roll_flags_t flags
);

  logic [SUM_W-1:0]      total_next;
  dice_pkg::roll_flags_t flags_next;
  dice_pkg::roll_flags_t flags_rst;

  always_comb begin
    total_next = SUM_W'(face_a) + SUM_W'(face_b);
    flags_next = dice_pkg::classify_total(int'(total_next), FACES);
    flags_rst  = dice_pkg::classify_total(2, FACES);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      total <= SUM_W'(2);
      flags <= flags_rst;
    end else begin
      total <= total_next;
      flags <= flags_next;
    end
  end

endmodule

// File: rtl/dice_roller.sv
module dice_roller #(
  parameter  int FACES  = 6,
  localparam int FACE_W = $clog2(FACES + 1),
  localparam int SUM_W  = $clog2(2 * FACES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              roll_en,
  output logic [FACE_W-1:0] die_a,
  output logic [FACE_W-1:0] die_b,
  output logic [SUM_W-1:0]  sum,
  output logic              sum_is_7,
  output logic              sum_7_or_11,
  output logic              sum_2_3_12
);

  localparam int NUM_DICE = 2;
  localparam logic [FACE_W-1:0] TOP = FACE_W'(FACES);

  logic [FACE_W-1:0]     faces [NUM_DICE];
  logic [NUM_DICE-1:0]   carry;
  dice_pkg::roll_flags_t flags;

  assign carry[0] = roll_en;

  for (genvar i = 0; i < NUM_DICE; i++) begin : g_die
    if (i > 0) begin : g_cascade
      assign carry[i] = carry[i-1] && (faces[i-1] == TOP);
    end
    dice_face_counter #(
      .FACES  (FACES),
      .FACE_W (FACE_W)
    ) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .step (carry[i]),
      .face (faces[i])
    );
  end

  dice_sum_decode #(
    .FACES  (FACES),
    .FACE_W (FACE_W),
    .SUM_W  (SUM_W)
  ) u_dec (
    .clk    (clk),
    .rst    (rst),
    .face_a (faces[0]),
    .face_b (faces[1]),
    .total  (sum),
    .flags  (flags)
  );

  assign die_a       = faces[0];
  assign die_b       = faces[1];
  assign sum_is_7    = flags.seven;
  assign sum_7_or_11 = flags.seven_or_eleven;
  assign sum_2_3_12  = flags.two_three_twelve;

endmodule

// File: rtl/dice_roller_chk.sv
module dice_roller_chk #(
  parameter  int FACES  = 6,
  localparam int FACE_W = $clog2(FACES + 1),
  localparam int SUM_W  = $clog2(2 * FACES + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              roll_en,
  input logic [FACE_W-1:0] die_a,
  input logic [FACE_W-1:0] die_b,
  input logic [SUM_W-1:0]  sum,
  input logic              sum_is_7,
  input logic              sum_7_or_11,
  input logic              sum_2_3_12
);

  localparam logic [FACE_W-1:0] TOP = FACE_W'(FACES);

  p_range_r1: assert property (@(posedge clk) disable iff (rst)
    (die_a >= 1) && (die_a <= TOP) && (die_b >= 1) && (die_b <= TOP));

  p_step_a_r2: assert property (@(posedge clk) disable iff (rst)
    (roll_en && die_a != TOP) |=> (die_a == $past(die_a) + 1'b1));

  p_wrap_a_r2: assert property (@(posedge clk) disable iff (rst)
    (roll_en && die_a == TOP) |=> (die_a == 1));

  p_b_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (roll_en && die_a != TOP) |=> $stable(die_b));

  p_b_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (roll_en && die_a == TOP && die_b != TOP) |=> (die_b == $past(die_b) + 1'b1));

  p_b_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (roll_en && die_a == TOP && die_b == TOP) |=> (die_b == 1));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !roll_en |=> ($stable(die_a) && $stable(die_b)));

  p_reset_r5: assert property (@(posedge clk)
    rst |=> (die_a == 1 && die_b == 1 && sum == 2 && sum_2_3_12 && !sum_is_7));

  p_sum_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sum == SUM_W'($past(die_a)) + SUM_W'($past(die_b))));

  p_seven_r7: assert property (@(posedge clk) disable iff (rst)
    sum_is_7 == (sum == SUM_W'(FACES + 1)));

  p_natural_r8: assert property (@(posedge clk) disable iff (rst)
    sum_7_or_11 == ((sum == SUM_W'(FACES + 1)) || (sum == SUM_W'(2 * FACES - 1))));

  p_craps_r9: assert property (@(posedge clk) disable iff (rst)
    sum_2_3_12 == ((sum == 2) || (sum == 3) || (sum == SUM_W'(2 * FACES))));

endmodule

bind dice_roller dice_roller_chk #(.FACES(FACES)) u_chk (.*);

// File: tb/sim_dice_roller.sv
module sim_dice_roller;

  localparam int CLK_PERIOD = 10;
  localparam int FACES      = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       roll_en = 1'b0;
  logic [2:0] die_a, die_b;
  logic [3:0] sum;
  logic       sum_is_7, sum_7_or_11, sum_2_3_12;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dice_roller #(.FACES(FACES)) u0 (
    .clk         (clk),
    .rst         (rst),
    .roll_en     (roll_en),
    .die_a       (die_a),
    .die_b       (die_b),
    .sum         (sum),
    .sum_is_7    (sum_is_7),
    .sum_7_or_11 (sum_7_or_11),
    .sum_2_3_12  (sum_2_3_12)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_a(input int n);
    return (n % FACES) + 1;
  endfunction

  function automatic int exp_b(input int n);
    return ((n / FACES) % FACES) + 1;
  endfunction

  task automatic check_totals(input int s);
    check("R6", "sum", int'(sum), s);
    check("R7", "seven flag", int'(sum_is_7), int'(s == 7));
    check("R8", "seven-or-eleven flag", int'(sum_7_or_11), int'(s == 7 || s == 11));
    check("R9", "two-three-twelve flag", int'(sum_2_3_12), int'(s == 2 || s == 3 || s == 12));
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    roll_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R5: reset state
    apply_reset();
    check("R5", "die_a after reset", int'(die_a), 1);
    check("R5", "die_b after reset", int'(die_b), 1);
    check("R5", "sum after reset", int'(sum), 2);
    check("R5", "flags after reset", {29'd0, sum_is_7, sum_7_or_11, sum_2_3_12}, 1);

    // Sweep of press lengths: R1, R3 closed form, R6..R9
    for (int n = 0; n < 72; n++) begin
      apply_reset();
      if (n > 0) begin
        roll_en = 1'b1;
        repeat (n) @(negedge clk);
        roll_en = 1'b0;
      end
      @(negedge clk);
      check("R1", "die_a in range", int'(die_a >= 1 && die_a <= FACES), 1);
      check("R1", "die_b in range", int'(die_b >= 1 && die_b <= FACES), 1);
      check("R3", "die_a after press", int'(die_a), exp_a(n));
      check("R3", "die_b after press", int'(die_b), exp_b(n));
      check_totals(exp_a(n) + exp_b(n));
    end

    // R4: values freeze while enable is low
    apply_reset();
    roll_en = 1'b1;
    repeat (23) @(negedge clk);
    roll_en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R4", "held die_a", int'(die_a), exp_a(23));
      check("R4", "held die_b", int'(die_b), exp_b(23));
    end
    check_totals(exp_a(23) + exp_b(23));

    // R2/R3/R6: continuous enable, cycle by cycle
    apply_reset();
    roll_en = 1'b1;
    for (int k = 1; k <= 80; k++) begin
      @(negedge clk);
      check("R2", "die_a per cycle", int'(die_a), exp_a(k));
      check("R3", "die_b per cycle", int'(die_b), exp_b(k));
      check("R6", "lagged sum", int'(sum), exp_a(k - 1) + exp_b(k - 1));
    end

    // R5: reset wins over an active enable
    rst = 1'b1;
    @(negedge clk);
    check("R5", "die_a reset priority", int'(die_a), 1);
    check("R5", "die_b reset priority", int'(die_b), 1);
    check("R5", "sum reset priority", int'(sum), 2);
    rst = 1'b0;
    roll_en = 1'b0;
    @(negedge clk);
    check("R4", "die_a after reset, idle", int'(die_a), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule